// File: doc/BRIEF.md
# Outbound Address Translator

This block translates local 64-bit request addresses into bus addresses through sixteen programmable windows. Each window has a 64-bit base, a 32-bit low word for its last address, a 64-bit target and a 5-bit transaction type. Software sets these through a 32-bit word-wide register port and reads them back over the same port. Each window is switched on by its own enable bit.

The lookup path has no registers. A request address is compared against every enabled window in the same cycle. On a hit the block drives the target plus the request's offset from the window base, the window's transaction type and the window number. On a miss it raises a miss flag instead. When windows overlap, the lowest-numbered window wins. A window's last address borrows its upper 32 bits from the window's upper base word.

Top module: `oatu_top`

## Requirements
- R1: After reset every window is disabled, every register reads back zero and every lookup misses.
- R2: A register sits at byte address 0x300000 | (window << 9) | offset. The offsets are: type 0x00, control 0x04, base low 0x08, base high 0x0C, last-address low 0x10, target low 0x14, target high 0x18. The type register keeps write bits 4:0 and reads zero above them. The control register keeps only its enable in bit 31 and reads zero in bits 30:0. The other registers keep all 32 bits.
- R3: Reads of any other offset inside a bank, or of any address whose bits 21:20 are not 2'b11 or whose bits 19:13 are not zero, return zero. Writes to such addresses change no register.
- R4: An enabled window hits when base <= request <= {base high, last-address low}. Both ends are inclusive.
- R5: On a hit the translated address is {target high, target low} + (request - base), modulo 2^64.
- R6: On a hit the type output equals bits 4:0 of the winning window's type register, and the region output equals the window number.
- R7: A window whose enable bit is clear never hits, whatever its address registers hold.
- R8: When several enabled windows hit, the lowest-numbered one drives the outputs.
- R9: On a miss, the miss output is 1, the hit output is 0, and the region, type and translated address outputs are all zero.
- R10: A written value is visible on readback and in the lookup from the first clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 22 | Register byte address, used for both reads and writes |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Readback of the register at regAddr (combinational) |
| reqAddr | input | 64 | Local request address to translate |
| lkHit | output | 1 | Request falls inside an enabled window |
| lkMiss | output | 1 | Request matches no enabled window |
| lkRegion | output | 4 | Winning window number |
| lkType | output | 5 | Winning window's transaction type |
| lkAddr | output | 64 | Translated bus address |

## Verification
Lookups are placed on a window's first and last byte and one byte beyond each end. This separates an inclusive comparison from an exclusive one. The same address is checked while a window is disabled and again once it is enabled, which shows that the enable gates the hit. Two overlapping windows are hit at a shared address, first with both enabled and then with the lower one disabled. This exposes a reversed priority. A window at the very top of the address space hits only if the last-address comparison borrows the upper base word. Readbacks of truncated fields, of unused offsets and of out-of-block writes show which bits are really kept.

// File: rtl/oatu_pkg.sv
package oatu_pkg;
  parameter int OATU_REGIONS = 16;
  parameter int OATU_IDX_W = $clog2(OATU_REGIONS);
  parameter int OATU_ADDR_W = 22;
  parameter int OATU_BANK_SHIFT = 9;
  parameter int OATU_TYPE_W = 5;
  parameter int OATU_EN_BIT = 31;

  typedef enum logic [2:0] {
    F_TYPE, F_CTRL, F_BASE_LO, F_BASE_HI, F_LAST_LO, F_TGT_LO, F_TGT_HI, F_NONE
  } field_e;

  typedef struct packed {
    logic                  wrEn;
    logic [OATU_IDX_W-1:0] idx;
    field_e                field;
    logic [31:0]           data;
  } strobe_t;
endpackage

// File: rtl/oatu_ctrl.sv
module oatu_ctrl
  import oatu_pkg::*;
#(
  parameter int AddrW = OATU_ADDR_W,
  parameter int BankShift = OATU_BANK_SHIFT,
  parameter int IdxW = OATU_IDX_W
) (
  input  logic             regWe,
  input  logic [AddrW-1:0] regAddr,
  input  logic [31:0]      regWdata,
  output strobe_t          strobe
);
  localparam int GapLo = BankShift + IdxW;
  localparam int GapHi = AddrW - 3;

  logic inBlock;
  logic [BankShift-1:0] offset;
  field_e field;

  assign inBlock = (regAddr[AddrW-1 -: 2] == 2'b11) && (regAddr[GapHi:GapLo] == '0);
  assign offset = regAddr[BankShift-1:0];

  always_comb begin
    field = F_NONE;
    if (inBlock) begin
      case (offset)
        9'h000: field = F_TYPE;
        9'h004: field = F_CTRL;
        9'h008: field = F_BASE_LO;
        9'h00C: field = F_BASE_HI;
        9'h010: field = F_LAST_LO;
        9'h014: field = F_TGT_LO;
        9'h018: field = F_TGT_HI;
        default: field = F_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.wrEn = regWe && (field != F_NONE);
    strobe.idx = regAddr[BankShift +: IdxW];
    strobe.field = field;
    strobe.data = regWdata;
  end
endmodule

// File: rtl/oatu_datapath.sv
module oatu_datapath
  import oatu_pkg::*;
#(
  parameter int Regions = OATU_REGIONS,
  parameter int IdxW = OATU_IDX_W,
  parameter int TypeW = OATU_TYPE_W,
  parameter int EnBit = OATU_EN_BIT
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  output logic [31:0]      regRdata,
  input  logic [63:0]      reqAddr,
  output logic             lkHit,
  output logic             lkMiss,
  output logic [IdxW-1:0]  lkRegion,
  output logic [TypeW-1:0] lkType,
  output logic [63:0]      lkAddr
);
  logic [TypeW-1:0] typeR  [Regions];
  logic             enR    [Regions];
  logic [31:0]      baseLo [Regions];
  logic [31:0]      baseHi [Regions];
  logic [31:0]      lastLo [Regions];
  logic [31:0]      tgtLo  [Regions];
  logic [31:0]      tgtHi  [Regions];
  logic [Regions-1:0] hitVec;

  for (genvar i = 0; i < Regions; i++) begin : g_region
    logic sel;
    logic [63:0] base64;
    logic [63:0] last64;
    assign sel = strobe.wrEn && (strobe.idx == IdxW'(i));
    assign base64 = {baseHi[i], baseLo[i]};
    assign last64 = {baseHi[i], lastLo[i]};
    assign hitVec[i] = enR[i] && (reqAddr >= base64) && (reqAddr <= last64);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        typeR[i] <= '0;
        enR[i] <= 1'b0;
        baseLo[i] <= '0;
        baseHi[i] <= '0;
        lastLo[i] <= '0;
        tgtLo[i] <= '0;
        tgtHi[i] <= '0;
      end else if (sel) begin
        case (strobe.field)
          F_TYPE:    typeR[i] <= strobe.data[TypeW-1:0];
          F_CTRL:    enR[i] <= strobe.data[EnBit];
          F_BASE_LO: baseLo[i] <= strobe.data;
          F_BASE_HI: baseHi[i] <= strobe.data;
          F_LAST_LO: lastLo[i] <= strobe.data;
          F_TGT_LO:  tgtLo[i] <= strobe.data;
          F_TGT_HI:  tgtHi[i] <= strobe.data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (strobe.field)
      F_TYPE:    regRdata = 32'(typeR[strobe.idx]);
      F_CTRL:    regRdata[EnBit] = enR[strobe.idx];
      F_BASE_LO: regRdata = baseLo[strobe.idx];
      F_BASE_HI: regRdata = baseHi[strobe.idx];
      F_LAST_LO: regRdata = lastLo[strobe.idx];
      F_TGT_LO:  regRdata = tgtLo[strobe.idx];
      F_TGT_HI:  regRdata = tgtHi[strobe.idx];
      default:   regRdata = '0;
    endcase
  end

  logic [IdxW-1:0] winIdx;
  always_comb begin
    winIdx = '0;
    for (int i = Regions - 1; i >= 0; i--) begin
      if (hitVec[i]) winIdx = IdxW'(i);
    end
  end

  always_comb begin
    lkHit = |hitVec;
    lkMiss = ~lkHit;
    lkRegion = '0;
    lkType = '0;
    lkAddr = '0;
    if (lkHit) begin
      lkRegion = winIdx;
      lkType = typeR[winIdx];
      lkAddr = {tgtHi[winIdx], tgtLo[winIdx]} + (reqAddr - {baseHi[winIdx], baseLo[winIdx]});
    end
  end
endmodule

// File: rtl/oatu_top.sv
module oatu_top
  import oatu_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [OATU_ADDR_W-1:0] regAddr,
  input  logic [31:0]            regWdata,
  output logic [31:0]            regRdata,
  input  logic [63:0]            reqAddr,
  output logic                   lkHit,
  output logic                   lkMiss,
  output logic [OATU_IDX_W-1:0]  lkRegion,
  output logic [OATU_TYPE_W-1:0] lkType,
  output logic [63:0]            lkAddr
);
  strobe_t strobe;

  oatu_ctrl u_ctrl (
    .regWe(regWe),
    .regAddr(regAddr),
    .regWdata(regWdata),
    .strobe(strobe)
  );

  oatu_datapath u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .regRdata(regRdata),
    .reqAddr(reqAddr),
    .lkHit(lkHit),
    .lkMiss(lkMiss),
    .lkRegion(lkRegion),
    .lkType(lkType),
    .lkAddr(lkAddr)
  );
endmodule

// File: rtl/oatu_chk.sv
module oatu_chk
  import oatu_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   regWe,
  input logic [OATU_ADDR_W-1:0] regAddr,
  input logic [31:0]            regWdata,
  input logic [31:0]            regRdata,
  input logic                   lkHit,
  input logic                   lkMiss,
  input logic [OATU_IDX_W-1:0]  lkRegion,
  input logic [OATU_TYPE_W-1:0] lkType,
  input logic [63:0]            lkAddr
);
  logic inBlk;
  logic [8:0] off;
  logic known;
  assign inBlk = (regAddr[21:20] == 2'b11) && (regAddr[19:13] == '0);
  assign off = regAddr[8:0];
  assign known = inBlk && (off <= 9'h018) && (off[1:0] == 2'b00);

  // R9: a miss drives every lookup output to zero
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    lkMiss |-> (!lkHit && lkRegion == '0 && lkType == '0 && lkAddr == '0));

  // R3: unused or foreign addresses read zero
  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !known |-> (regRdata == '0));

  // R2: the type register reads zero above bit 4
  p_type_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inBlk && off == 9'h000) |-> (regRdata[31:5] == '0));

  // R10: an enable write is visible on readback from the next edge
  p_enable_visible_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && inBlk && off == 9'h004) |=>
      (regAddr != $past(regAddr) ||
       (regRdata[31] == $past(regWdata[31]) && regRdata[30:0] == '0)));
endmodule

bind oatu_top oatu_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regRdata(regRdata), .lkHit(lkHit), .lkMiss(lkMiss),
  .lkRegion(lkRegion), .lkType(lkType), .lkAddr(lkAddr)
);

// File: tb/oatu_top_tb.sv
module oatu_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [21:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [63:0] reqAddr = '0;
  logic lkHit, lkMiss;
  logic [3:0] lkRegion;
  logic [4:0] lkType;
  logic [63:0] lkAddr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  oatu_top u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqAddr(reqAddr),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkRegion(lkRegion),
    .lkType(lkType), .lkAddr(lkAddr)
  );

  typedef struct {
    bit isRd;
    logic [31:0] rd;
    bit hit;
    logic [3:0] idx;
    logic [4:0] ty;
    logic [63:0] xa;
    string tag;
  } item_t;

  item_t q[$];

  function automatic logic [21:0] bank(int idx, int off);
    return 22'h300000 | 22'(idx << 9) | 22'(off);
  endfunction

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdExp(logic [21:0] a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    regAddr = a;
    it.isRd = 1; it.rd = e; it.hit = 0; it.idx = 0; it.ty = 0; it.xa = 0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic look(logic [63:0] a, bit h, logic [3:0] i, logic [4:0] t,
                      logic [63:0] x, string tag);
    item_t it;
    @(negedge clk);
    reqAddr = a;
    it.isRd = 0; it.rd = 0; it.hit = h; it.idx = h ? i : 4'd0;
    it.ty = h ? t : 5'd0; it.xa = h ? x : 64'd0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic prog(int i, logic [31:0] ty, logic [63:0] base, logic [31:0] lastLo,
                      logic [63:0] tgt);
    wr(bank(i, 'h00), ty);
    wr(bank(i, 'h08), base[31:0]);
    wr(bank(i, 'h0C), base[63:32]);
    wr(bank(i, 'h10), lastLo);
    wr(bank(i, 'h14), tgt[31:0]);
    wr(bank(i, 'h18), tgt[63:32]);
  endtask

  // monitor: pops one expected item per edge and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        total++;
        if (e.isRd) begin
          if (regRdata !== e.rd) begin
            bad++;
            $display("FAIL %s: rdata=%h expected=%h", e.tag, regRdata, e.rd);
          end
        end else begin
          if (lkHit !== e.hit || lkMiss !== !e.hit || lkRegion !== e.idx ||
              lkType !== e.ty || lkAddr !== e.xa) begin
            bad++;
            $display("FAIL %s: hit=%b miss=%b reg=%0d type=%h addr=%h expected hit=%b reg=%0d type=%h addr=%h",
                     e.tag, lkHit, lkMiss, lkRegion, lkType, lkAddr, e.hit, e.idx, e.ty, e.xa);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rdExp(bank(0, 'h04), 32'h0, "R1 ctrl after reset");
    rdExp(bank(7, 'h08), 32'h0, "R1 base after reset");
    rdExp(bank(15, 'h18), 32'h0, "R1 target after reset");
    look(64'h0, 0, 0, 0, 0, "R1 lookup zero after reset");
    look(64'h1234_5678, 0, 0, 0, 0, "R1 lookup after reset");

    // window 2, still disabled
    prog(2, 32'hFFFF_FFEA, 64'h0000_0001_1000_0000, 32'h1000_FFFF, 64'h0000_0080_0000_0000);
    rdExp(bank(2, 'h00), 32'h0000_000A, "R2 type keeps low five bits");
    rdExp(bank(2, 'h08), 32'h1000_0000, "R2 base low");
    rdExp(bank(2, 'h0C), 32'h0000_0001, "R2 base high");
    rdExp(bank(2, 'h10), 32'h1000_FFFF, "R2 last low");
    rdExp(bank(2, 'h14), 32'h0000_0000, "R2 target low");
    rdExp(bank(2, 'h18), 32'h0000_0080, "R2 target high");
    look(64'h1_1000_0000, 0, 0, 0, 0, "R7 disabled window misses");

    // R3: unused offsets and foreign addresses
    wr(bank(2, 'h1C), 32'hDEAD_BEEF);
    rdExp(bank(2, 'h1C), 32'h0, "R3 unused offset reads zero");
    wr(22'h200008, 32'hCAFE_F00D);
    rdExp(bank(0, 'h08), 32'h0, "R3 foreign write ignored");
    rdExp(22'h200008, 32'h0, "R3 foreign read zero");

    // R10: enable visible next edge (write then immediate read)
    wr(bank(2, 'h04), 32'hFFFF_FFFF);
    rdExp(bank(2, 'h04), 32'h8000_0000, "R10 enable readback, R2 ctrl bits");

    // R4/R5/R6 window edges
    look(64'h1_1000_0000, 1, 2, 5'h0A, 64'h80_0000_0000, "R4 first byte hits R5 R6");
    look(64'h1_1000_FFFF, 1, 2, 5'h0A, 64'h80_0000_FFFF, "R4 last byte hits R5");
    look(64'h1_1001_0000, 0, 0, 0, 0, "R4 one past end misses R9");
    look(64'h1_0FFF_FFFF, 0, 0, 0, 0, "R4 one before base misses");
    look(64'h0_1000_0000, 0, 0, 0, 0, "R4 wrong upper word misses");

    // R8: overlapping window 5
    prog(5, 32'h4, 64'h1_1000_8000, 32'h1000_FFFF, 64'h2000);
    wr(bank(5, 'h04), 32'h8000_0000);
    look(64'h1_1000_9000, 1, 2, 5'h0A, 64'h80_0000_9000, "R8 lowest index wins");
    wr(bank(2, 'h04), 32'h0);
    look(64'h1_1000_9000, 1, 5, 5'h04, 64'h3000, "R7 R8 disabled lower yields to 5");
    look(64'h1_1000_0000, 0, 0, 0, 0, "R7 disabled window 2 base misses");

    // R4: upper last word taken from base high, top of space
    prog(15, 32'h1F, 64'hFFFF_FFFF_0000_0000, 32'hFFFF_FFFF, 64'h0);
    wr(bank(15, 'h04), 32'h8000_0000);
    look(64'hFFFF_FFFF_FFFF_FFFF, 1, 15, 5'h1F, 64'hFFFF_FFFF, "R4 top of space hits");
    look(64'hFFFF_FFFE_FFFF_FFFF, 0, 0, 0, 0, "R4 below top window misses");

    // R5 wraparound: target above base offset
    prog(9, 32'h3, 64'h10, 32'h1F, 64'hFFFF_FFFF_FFFF_FFF8);
    wr(bank(9, 'h04), 32'h8000_0000);
    look(64'h1A, 1, 9, 5'h03, 64'h2, "R5 translated address wraps");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule